// File: doc/BRIEF.md
# Software Store Command Detector

This block sits beside a byte-wide memory with nonvolatile backup and watches every access that reaches it. A nonvolatile store is requested by software without any command register: the host reads six fixed addresses, one after the other, with nothing else in between. When the detector sees the sixth read of that chain, it emits a one-cycle start pulse and raises a busy flag. The busy flag shuts the memory interface for a fixed number of clock cycles. The busy window is split into an erase phase followed by a program phase, and each phase has its own flag so that the cell controller can sequence them.

Each access is presented as a single-cycle strobe together with a 15-bit address. The read strobe marks a read cycle that chip enable controls. Output enable plays no part, so it is not an input. A write strobe, or a read of any address that does not continue the chain, silently drops the progress made so far. A read of the chain's opening address always counts as a new first step, even when that same read breaks a chain in progress. While the store runs, and whenever the device reports itself busy through `devBusy`, every access is ignored. After a store completes, the matcher starts again from the beginning.

Top module: `storeSeqDetector`

## Requirements
- R1: During and directly after reset, `storeStart`, `storeBusy`, `erasePhase` and `programPhase` are all low, and the matcher expects the first address of the chain.
- R2: Reads of 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0FC0, in that order, start a store. `storeStart` is high for exactly the one cycle that follows the clock edge that samples the sixth read.
- R3: A read of an address other than the next one expected, made while the chain is in progress, returns the matcher to its first step, and no store follows from the rest of that chain.
- R4: A write strobe at any step, whatever its address and even when `rdStrobe` is high at the same time, returns the matcher to its first step, and no store follows.
- R5: A read of 0x0E38 that breaks a chain counts as the first step of a new chain.
- R6: `storeBusy` rises in the same cycle as `storeStart` and stays high for exactly STORE_CYC cycles. After that, accesses are accepted again.
- R7: During a store, `erasePhase` is high for the first ERASE_CYC busy cycles and `programPhase` is high for the remaining cycles. The two flags are never high together, and program never comes before erase.
- R8: Accesses made while `storeBusy` is high are ignored. They neither advance nor break the chain, and after the store the matcher expects the first address again.
- R9: Accesses made while `devBusy` is high are ignored and leave the progress of the chain unchanged.
- R10: Cycles with neither strobe high leave the matcher unchanged, so idle gaps of any length may separate the steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 15 | Address of the access being strobed |
| rdStrobe | input | 1 | One-cycle pulse for a read cycle controlled by chip enable |
| wrStrobe | input | 1 | One-cycle pulse for a write cycle |
| devBusy | input | 1 | Device busy for another reason; accesses are ignored while high |
| storeStart | output | 1 | One-cycle pulse when a store begins |
| storeBusy | output | 1 | High while a store blocks the memory interface |
| erasePhase | output | 1 | High during the erase part of a store |
| programPhase | output | 1 | High during the program part of a store |

## Verification
The chain is applied back to back and with idle gaps between steps, which shows that strobe-free cycles carry no meaning. It is also broken in several ways: by a wrong read, by a write at the middle step and at the final step, and by a read of 0x0E38 in the middle. These cases tell a full reset apart from a restart at step one. Accesses made during a store and while `devBusy` is high show the difference between an access that is ignored and one that aborts the chain. In the first case a later completion of the chain still starts a store; in the second it does not. Every cycle, the phase flags and the length of the busy window are compared against a behavioural timer.

// File: rtl/storeSeqPkg.sv
`timescale 1ns/1ps
package storeSeqPkg;
  localparam int ADDR_W  = 15;
  localparam int SEQ_LEN = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_PROGRAM} storeStateT;

  typedef struct packed {
    logic stepAdvance;
    logic stepRestart;
    logic stepClear;
    logic timerStart;
    logic timerRun;
  } ctlStrobesT;

  // Fixed command chain; the order is behaviour.
  function automatic logic [ADDR_W-1:0] seqAddr(input int idx);
    case (idx)
      0:       seqAddr = 15'h0E38;
      1:       seqAddr = 15'h31C7;
      2:       seqAddr = 15'h03E0;
      3:       seqAddr = 15'h3C1F;
      4:       seqAddr = 15'h303F;
      default: seqAddr = 15'h0FC0;
    endcase
  endfunction
endpackage

// File: rtl/seqDatapath.sv
`timescale 1ns/1ps
module seqDatapath
  import storeSeqPkg::*;
#(
  parameter int ERASE_CYC = 8,
  parameter int STORE_CYC = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  ctlStrobesT        ctl,
  output logic              matchNext,
  output logic              matchFirst,
  output logic              lastStep,
  output logic              eraseDone,
  output logic              storeDone
);
  localparam int STEP_W = $clog2(SEQ_LEN);
  localparam int TMR_W  = $clog2(STORE_CYC + 1);

  logic [STEP_W-1:0]  stepIdx;
  logic [TMR_W-1:0]   tmr;
  logic [SEQ_LEN-1:0] hitVec;

  // One comparator per chain position.
  for (genvar g = 0; g < SEQ_LEN; g++) begin : gHit
    assign hitVec[g] = (addr == seqAddr(g));
  end

  assign matchNext  = hitVec[stepIdx];
  assign matchFirst = hitVec[0];
  assign lastStep   = (stepIdx == STEP_W'(SEQ_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN)                stepIdx <= '0;
    else if (ctl.stepClear)   stepIdx <= '0;
    else if (ctl.stepRestart) stepIdx <= STEP_W'(1);
    else if (ctl.stepAdvance) stepIdx <= stepIdx + STEP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)               tmr <= '0;
    else if (ctl.timerStart) tmr <= '0;
    else if (ctl.timerRun)   tmr <= tmr + TMR_W'(1);
  end

  assign eraseDone = (tmr == TMR_W'(ERASE_CYC - 1));
  assign storeDone = (tmr == TMR_W'(STORE_CYC - 1));
endmodule

// File: rtl/seqControl.sv
`timescale 1ns/1ps
module seqControl
  import storeSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdStrobe,
  input  logic       wrStrobe,
  input  logic       devBusy,
  input  logic       matchNext,
  input  logic       matchFirst,
  input  logic       lastStep,
  input  logic       eraseDone,
  input  logic       storeDone,
  output ctlStrobesT ctl,
  output logic       storeStart,
  output logic       storeBusy,
  output logic       erasePhase,
  output logic       programPhase
);
  storeStateT state, stateNxt;
  logic       launch;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    launch   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (!devBusy) begin
          if (wrStrobe) begin
            ctl.stepClear = 1'b1;
          end else if (rdStrobe) begin
            if (matchNext && lastStep) begin
              launch         = 1'b1;
              ctl.stepClear  = 1'b1;
              ctl.timerStart = 1'b1;
              stateNxt       = ST_ERASE;
            end else if (matchNext) begin
              ctl.stepAdvance = 1'b1;
            end else if (matchFirst) begin
              ctl.stepRestart = 1'b1;
            end else begin
              ctl.stepClear = 1'b1;
            end
          end
        end
      end
      ST_ERASE: begin
        ctl.timerRun = 1'b1;
        if (eraseDone) stateNxt = ST_PROGRAM;
      end
      ST_PROGRAM: begin
        ctl.timerRun = 1'b1;
        if (storeDone) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      storeStart <= 1'b0;
    end else begin
      state      <= stateNxt;
      storeStart <= launch;
    end
  end

  assign storeBusy    = (state != ST_IDLE);
  assign erasePhase   = (state == ST_ERASE);
  assign programPhase = (state == ST_PROGRAM);
endmodule

// File: rtl/storeSeqDetector.sv
`timescale 1ns/1ps
module storeSeqDetector
  import storeSeqPkg::*;
#(
  parameter int ERASE_CYC = 8,
  parameter int STORE_CYC = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [14:0] addr,
  input  logic        rdStrobe,
  input  logic        wrStrobe,
  input  logic        devBusy,
  output logic        storeStart,
  output logic        storeBusy,
  output logic        erasePhase,
  output logic        programPhase
);
  ctlStrobesT ctl;
  logic matchNext, matchFirst, lastStep, eraseDone, storeDone;

  seqDatapath #(.ERASE_CYC(ERASE_CYC), .STORE_CYC(STORE_CYC)) uDp (
    .clk(clk), .rstN(rstN), .addr(addr), .ctl(ctl),
    .matchNext(matchNext), .matchFirst(matchFirst), .lastStep(lastStep),
    .eraseDone(eraseDone), .storeDone(storeDone)
  );

  seqControl uCtl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .devBusy(devBusy), .matchNext(matchNext), .matchFirst(matchFirst),
    .lastStep(lastStep), .eraseDone(eraseDone), .storeDone(storeDone),
    .ctl(ctl), .storeStart(storeStart), .storeBusy(storeBusy),
    .erasePhase(erasePhase), .programPhase(programPhase)
  );
endmodule

// File: rtl/storeSeqChecker.sv
`timescale 1ns/1ps
module storeSeqChecker #(
  parameter int ERASE_CYC = 8,
  parameter int STORE_CYC = 20
) (
  input logic clk,
  input logic rstN,
  input logic rdStrobe,
  input logic wrStrobe,
  input logic devBusy,
  input logic storeStart,
  input logic storeBusy,
  input logic erasePhase,
  input logic programPhase
);
  int busyCnt;
  int eraseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt  <= 0;
      eraseCnt <= 0;
    end else begin
      busyCnt  <= storeBusy ? busyCnt + 1 : 0;
      eraseCnt <= erasePhase ? eraseCnt + 1 : 0;
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |=> !storeStart); // R2
  AST_WRITE_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !storeBusy && !devBusy) |=> !storeStart); // R4
  AST_BUSY_WITH_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(storeBusy) |-> storeStart); // R6
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(storeBusy) |-> (busyCnt == STORE_CYC)); // R6
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(erasePhase && programPhase)); // R7
  AST_ERASE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(programPhase) |-> (eraseCnt == ERASE_CYC)); // R7
  AST_START_IN_ERASE: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |-> erasePhase); // R7
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    storeBusy |=> (!storeStart || !$past(storeBusy))); // R8
endmodule

bind storeSeqDetector storeSeqChecker #(.ERASE_CYC(ERASE_CYC), .STORE_CYC(STORE_CYC)) uChk (
  .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .devBusy(devBusy),
  .storeStart(storeStart), .storeBusy(storeBusy), .erasePhase(erasePhase),
  .programPhase(programPhase)
);

// File: tb/tb_storeSeqDetector.sv
`timescale 1ns/1ps
module tb_storeSeqDetector;
  localparam int ERASE_CYC = 8;
  localparam int STORE_CYC = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] addr = '0;
  logic        rdStrobe = 1'b0, wrStrobe = 1'b0, devBusy = 1'b0;
  logic        storeStart, storeBusy, erasePhase, programPhase;

  always #10 clk = ~clk;

  storeSeqDetector #(.ERASE_CYC(ERASE_CYC), .STORE_CYC(STORE_CYC)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .devBusy(devBusy), .storeStart(storeStart), .storeBusy(storeBusy),
    .erasePhase(erasePhase), .programPhase(programPhase)
  );

  logic [14:0] chain [6] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0FC0};

  int    checks = 0, fails = 0, startSeen = 0;
  int    mStep = 0, mT = -1;
  bit    mStart = 0;
  bit    done = 0;
  string curReq = "R1";

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check(curReq, "storeStart", int'(storeStart), int'(mStart));
    check(curReq, "storeBusy", int'(storeBusy), int'(mT >= 0));
    check(curReq, "erasePhase", int'(erasePhase), int'(mT >= 0 && mT < ERASE_CYC));
    check(curReq, "programPhase", int'(programPhase), int'(mT >= ERASE_CYC));
  endtask

  // Behavioural reference: one clock edge with the given inputs.
  task automatic cyc(input bit rd, input bit wr, input logic [14:0] a, input bit db);
    rdStrobe = rd; wrStrobe = wr; addr = a; devBusy = db;
    @(posedge clk);
    mStart = 0;
    if (mT >= 0) begin
      mT++;
      if (mT == STORE_CYC) mT = -1;
    end else if (!db && (rd || wr)) begin
      if (wr) mStep = 0;
      else if (a == chain[mStep]) begin
        if (mStep == 5) begin mStep = 0; mT = 0; mStart = 1; end
        else mStep++;
      end else mStep = (a == chain[0]) ? 1 : 0;
    end
    @(negedge clk);
    if (storeStart) startSeen++;
    compareAll();
    rdStrobe = 0; wrStrobe = 0; devBusy = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 15'h0, 0);
  endtask

  task automatic steps(input int first, input int last, input int gap);
    for (int i = first; i <= last; i++) begin
      cyc(1, 0, chain[i], 0);
      idle(gap);
    end
  endtask

  task automatic expectStarts(input string req, input int n);
    check(req, "store count", startSeen, n);
    startSeen = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    curReq = "R1";
    compareAll();
    rstN = 1'b1;
    idle(2);

    // R2 R10: chain with idle gaps, then the full store window (R6 R7)
    curReq = "R2"; steps(0, 5, 3);
    curReq = "R6"; idle(STORE_CYC + 2);
    expectStarts("R2", 1);

    // R2: back to back
    curReq = "R2"; steps(0, 5, 0);
    curReq = "R7"; idle(STORE_CYC + 1);
    expectStarts("R2", 1);

    // R3: wrong read mid chain, remaining steps give no store
    curReq = "R3"; steps(0, 2, 1); cyc(1, 0, 15'h1234, 0); steps(3, 5, 0); idle(3);
    expectStarts("R3", 0);

    // R4: write at middle step, with a read strobe alongside
    curReq = "R4"; steps(0, 2, 0); cyc(1, 1, chain[3], 0); steps(4, 5, 0); idle(3);
    expectStarts("R4", 0);
    // R4: write of the final address in place of the sixth read
    steps(0, 4, 0); cyc(0, 1, chain[5], 0); idle(3);
    expectStarts("R4", 0);

    // R5: aborting read of the first address restarts at step one
    curReq = "R5"; steps(0, 3, 0); cyc(1, 0, chain[0], 0); steps(1, 5, 1);
    idle(STORE_CYC + 1);
    expectStarts("R5", 1);

    // R8: accesses during store are ignored; matcher idle afterwards
    curReq = "R8"; steps(0, 5, 0);
    steps(0, 2, 0); cyc(0, 1, 15'h0111, 0); cyc(1, 0, 15'h7FFF, 0);
    idle(STORE_CYC);
    steps(3, 5, 0); idle(3);
    expectStarts("R8", 1);
    steps(0, 5, 0); idle(STORE_CYC + 1);
    expectStarts("R8", 1);

    // R9: devBusy hides a wrong read and a write
    curReq = "R9"; steps(0, 2, 0);
    cyc(1, 0, 15'h5555, 1); cyc(0, 1, chain[3], 1);
    steps(3, 5, 0); idle(STORE_CYC + 1);
    expectStarts("R9", 1);

    // R10: long gaps between steps
    curReq = "R10"; steps(0, 5, 9); idle(STORE_CYC + 1);
    expectStarts("R10", 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule